// File: doc/BRIEF.md
# ADC Prescaler and Conversion Sequencer

This block is the digital timing controller of a 10-bit successive-approximation converter. It runs in the CPU clock domain. A 7-bit prescaler turns the CPU clock into a one-cycle ADC clock-enable tick at a selectable ratio. A sequencer counts those ticks to walk each conversion through its steps. It raises a sample-and-hold strobe at a half-tick offset, and it drives a successive-approximation register (SAR) whose value goes to an external DAC. It then stores the finished code and raises a completion flag.

Software controls the block with a few plain control pins. One enables the converter. A one-cycle pulse arms a start bit. Another selects free-running operation, and a 3-bit field selects the ratio. A write-one pulse clears the flag. The analog comparator is a single input bit: 1 means the sampled input is at or above the current DAC value. No data stream crosses the block's edge. The result is a plain register that the completion flag qualifies, so no valid/ready handshake and no back-pressure rule applies.

Top module: `adc_seq_top`

## Requirements
- R1: The prescaler counts CPU cycles from zero and emits a one-cycle tick each time its low k bits are all ones. The divide ratio is 2^k. Select 000 and 001 give /2, and 010 through 111 give /4, /8, /16, /32, /64 and /128. The first tick after enable rises therefore comes in the ratio-th enabled cycle.
- R2: While enable is low the prescaler is held at zero and no tick is produced.
- R3: A start pulse sets the start bit only while enable is high. A conversion begins on the first tick after the start bit is already high, never in the cycle that sets it.
- R4: A normal conversion ends on the 13th tick after the tick that began it, and busy is high in between.
- R5: The first conversion after enable rises ends on the 25th tick.
- R6: The sample strobe is one CPU cycle long. It fires at the mid-point between tick 1 and tick 2 of a normal conversion, and between tick 13 and tick 14 of a first conversion. The mid-point is the cycle where the prescaler's low k bits equal 2^(k-1)-1.
- R7: At the sample strobe the DAC output becomes 10'h200. On each of the next 10 ticks one bit is decided, from MSB to LSB. The bit under trial stays set if the comparator is 1 and is cleared if it is 0, and the next lower bit is set as the new trial. The stored result then equals the input code.
- R8: On the completing tick the result register takes the SAR value and the flag sets. In single mode the start bit clears in the same cycle. The result register changes at no other time.
- R9: In free-running mode the completing tick also begins the next conversion, so busy and start stay high with no software action.
- R10: A flag-clear pulse clears the flag. If a completion happens in the same cycle, the flag stays set.
- R11: Dropping enable during a conversion aborts it. Busy, start and the DAC value go to zero and the result is left unchanged. The next conversion is a 25-tick first conversion again.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| start_set_i | input | 1 | One-cycle pulse that arms the start bit |
| free_run_i | input | 1 | Free-running mode select |
| psel_i | input | 3 | Prescale select |
| flag_clr_i | input | 1 | Write-one pulse that clears the completion flag |
| cmp_i | input | 1 | Comparator decision (1: input >= DAC value) |
| adc_tick_o | output | 1 | Divided ADC clock enable |
| busy_o | output | 1 | Conversion in progress |
| start_o | output | 1 | Start bit |
| sample_o | output | 1 | Sample-and-hold strobe |
| dac_o | output | 10 | SAR trial value to the DAC |
| result_o | output | 10 | Last completed conversion code |
| flag_o | output | 1 | Completion flag |

## Verification
The hardest case to reach is a flag-clear that lands in the same CPU cycle as a completion, since completion is tied to a specific tick deep inside a conversion. The bench holds the clear pin high through a free-running sequence, so every completion collides with a clear. A second hard case is an abort that re-arms the long first conversion. The bench reaches it by dropping enable part-way through a /128 conversion and then timing the next conversion in ticks. A behavioural model with its own integer counters follows every cycle, and a comparator driven from a target code closes the SAR loop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_t;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PRE_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] psel,
  output logic             tick,
  output logic             mid
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;
  logic [SEL_W-1:0] eff_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // select 0 behaves as select 1 (divide by two)
  always_comb begin
    eff_k = (psel == '0) ? SEL_W'(1) : psel;
    mask  = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(eff_k)) mask[i] = 1'b1;
    end
  end

  assign tick = en && ((cnt & mask) == mask);
  assign mid  = en && ((cnt & mask) == (mask >> 1));
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output logic [RES_W-1:0] sar
);
  logic [RES_W-1:0] nxt;

  always_comb begin
    nxt = sar;
    for (int i = 0; i < RES_W; i++) begin
      if (i == int'(bit_idx))          nxt[i] = cmp;
      else if (i + 1 == int'(bit_idx)) nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sar <= '0;
    else if (clr)  sar <= '0;
    else if (load) sar <= RES_W'(1) << (RES_W - 1);
    else if (step) sar <= nxt;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int NORM_LEN   = 13,
  parameter int FIRST_LEN  = 25,
  parameter int NORM_SAMP  = 1,
  parameter int FIRST_SAMP = 13,
  localparam int CYC_W = $clog2(FIRST_LEN + 1),
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_set,
  input  logic             free_run,
  input  logic             flag_clr,
  input  logic             tick,
  input  logic             mid,
  output logic             busy,
  output logic             start_q,
  output logic             flag,
  output logic             sample,
  output logic             sar_clr,
  output logic             sar_step,
  output logic [IDX_W-1:0] bit_idx,
  output logic             done
);
  seq_state_t       state;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] n_tick;
  logic [CYC_W-1:0] len;
  logic [CYC_W-1:0] samp;
  logic             first;
  logic             begin_c;
  logic             in_conv;

  always_comb begin
    len     = first ? CYC_W'(FIRST_LEN) : CYC_W'(NORM_LEN);
    samp    = first ? CYC_W'(FIRST_SAMP) : CYC_W'(NORM_SAMP);
    n_tick  = cyc + 1'b1;
    in_conv = en && (state == SEQ_CONV);
    begin_c = en && (state == SEQ_IDLE) && start_q && tick;
    done    = in_conv && tick && (n_tick == len);
    sample  = in_conv && mid && (cyc == samp);
    sar_step = in_conv && tick && (n_tick > samp) &&
               (n_tick <= samp + CYC_W'(RES_W));
    bit_idx = IDX_W'(samp + CYC_W'(RES_W) - n_tick);
    sar_clr = !en;
  end

  assign busy = (state == SEQ_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cyc     <= '0;
      start_q <= 1'b0;
      first   <= 1'b1;
    end else if (!en) begin
      state   <= SEQ_IDLE;
      cyc     <= '0;
      start_q <= 1'b0;
      first   <= 1'b1;
    end else begin
      if (start_set && !start_q) start_q <= 1'b1;
      case (state)
        SEQ_IDLE: if (begin_c) begin
          state <= SEQ_CONV;
          cyc   <= '0;
        end
        SEQ_CONV: if (tick) begin
          if (done) begin
            first <= 1'b0;
            cyc   <= '0;
            if (!free_run) begin
              state   <= SEQ_IDLE;
              start_q <= 1'b0;
            end
          end else begin
            cyc <= n_tick;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (done)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int RES_W      = 10,
  parameter int PRE_W      = 7,
  parameter int SEL_W      = 3,
  parameter int NORM_LEN   = 13,
  parameter int FIRST_LEN  = 25,
  parameter int NORM_SAMP  = 1,
  parameter int FIRST_SAMP = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_set_i,
  input  logic             free_run_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic             flag_clr_i,
  input  logic             cmp_i,
  output logic             adc_tick_o,
  output logic             busy_o,
  output logic             start_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic             tick, mid, sample, sar_clr, sar_step, done;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] sar;

  adc_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_i), .psel(psel_i),
    .tick(tick), .mid(mid)
  );

  adc_seq_ctrl #(
    .RES_W(RES_W), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN),
    .NORM_SAMP(NORM_SAMP), .FIRST_SAMP(FIRST_SAMP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en_i), .start_set(start_set_i),
    .free_run(free_run_i), .flag_clr(flag_clr_i), .tick(tick), .mid(mid),
    .busy(busy_o), .start_q(start_o), .flag(flag_o), .sample(sample),
    .sar_clr(sar_clr), .sar_step(sar_step), .bit_idx(bit_idx), .done(done)
  );

  adc_sar #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(sar_clr), .load(sample),
    .step(sar_step), .bit_idx(bit_idx), .cmp(cmp_i), .sar(sar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result_o <= '0;
    else if (done) result_o <= sar;
  end

  assign adc_tick_o = tick;
  assign sample_o   = sample;
  assign dac_o      = sar;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             free_run_i,
  input logic             flag_clr_i,
  input logic             adc_tick_o,
  input logic             busy_o,
  input logic             start_o,
  input logic             sample_o,
  input logic [RES_W-1:0] result_o,
  input logic             flag_o
);
  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick_o |=> !adc_tick_o);
  a_r2_quiet_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !adc_tick_o);
  a_r3_begin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(adc_tick_o) && $past(start_o));
  a_r6_sample_inside: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o && !adc_tick_o);
  a_r8_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(busy_o) && $past(adc_tick_o));
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> $past(busy_o) && $past(adc_tick_o));
  a_r8_single_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) && !$past(free_run_i) |-> !start_o);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && flag_clr_i && !adc_tick_o |=> !flag_o);
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_o && !start_o);
endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/adc_seq_top_test.sv
`timescale 1ns/1ps
module adc_seq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0, start_set_i = 1'b0, free_run_i = 1'b0, flag_clr_i = 1'b0;
  logic [2:0] psel_i = 3'd0;
  logic       cmp_i;
  logic       adc_tick_o, busy_o, start_o, sample_o, flag_o;
  logic [9:0] dac_o, result_o;
  int vin = 0;
  int n_chk = 0, n_fail = 0;
  bit model_on = 0, ended = 0;

  always #5 clk = ~clk;

  adc_seq_top uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_set_i(start_set_i),
    .free_run_i(free_run_i), .psel_i(psel_i), .flag_clr_i(flag_clr_i),
    .cmp_i(cmp_i), .adc_tick_o(adc_tick_o), .busy_o(busy_o),
    .start_o(start_o), .sample_o(sample_o), .dac_o(dac_o),
    .result_o(result_o), .flag_o(flag_o)
  );

  assign cmp_i = (vin >= int'(dac_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_ticks = 0, m_sar = 0, m_res = 0;
  bit m_busy = 0, m_st = 0, m_first = 1, m_flag = 0;

  function automatic int divv();
    return (psel_i == 3'd0) ? 2 : (1 << psel_i);
  endfunction

  always @(posedge clk) begin
    int d, len, samp, n, b;
    bit tk, md, st0, dn;
    if (!rst_n) begin
      m_cnt = 0; m_ticks = 0; m_sar = 0; m_res = 0;
      m_busy = 0; m_st = 0; m_first = 1; m_flag = 0;
    end else begin
      st0 = m_st; dn = 0;
      if (!en_i) begin
        m_cnt = 0; m_busy = 0; m_st = 0; m_first = 1; m_sar = 0; m_ticks = 0;
      end else begin
        d = divv();
        tk = (m_cnt % d) == d - 1;
        md = (m_cnt % d) == d / 2 - 1;
        len = m_first ? 25 : 13;
        samp = m_first ? 13 : 1;
        if (m_busy) begin
          if (md && m_ticks == samp) m_sar = 512;
          if (tk) begin
            n = m_ticks + 1;
            if (n > samp && n <= samp + 10) begin
              b = samp + 10 - n;
              if (vin < m_sar) m_sar = m_sar & ~(1 << b);
              if (b > 0) m_sar = m_sar | (1 << (b - 1));
            end
            if (n == len) begin
              dn = 1; m_res = m_sar; m_first = 0; m_ticks = 0;
              if (!free_run_i) begin m_busy = 0; m_st = 0; end
            end else m_ticks = n;
          end
        end else if (st0 && tk) begin
          m_busy = 1; m_ticks = 0;
        end
        if (start_set_i && !st0) m_st = 1;
        m_cnt = (m_cnt + 1) % 128;
      end
      if (dn) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    int d;
    bit e_tick, e_samp;
    #1;
    if (model_on && rst_n) begin
      d = divv();
      e_tick = en_i && ((m_cnt % d) == d - 1);
      e_samp = en_i && m_busy && ((m_cnt % d) == d / 2 - 1) &&
               (m_ticks == (m_first ? 13 : 1));
      chk(adc_tick_o == e_tick, "R1,R2 tick", adc_tick_o, e_tick);
      chk(busy_o == m_busy, "R3,R4,R5,R9,R11 busy", busy_o, m_busy);
      chk(start_o == m_st, "R3,R8,R9 start", start_o, m_st);
      chk(sample_o == e_samp, "R6 sample", sample_o, e_samp);
      chk(int'(dac_o) == m_sar, "R7 dac", dac_o, m_sar);
      chk(int'(result_o) == m_res, "R8 result", result_o, m_res);
      chk(flag_o == m_flag, "R8,R10 flag", flag_o, m_flag);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_set_i = 1'b1;
    @(negedge clk); start_set_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  // counts ticks from the start of busy up to and including the completing tick
  task automatic run_one(input int exp_len, input string tag);
    int ticks = 0, guard = 0;
    pulse_start();
    while (!busy_o && guard < 5000) begin @(negedge clk); guard++; end
    while (!flag_o && guard < 20000) begin
      if (adc_tick_o) ticks++;
      @(negedge clk); guard++;
    end
    #2;
    chk(ticks == exp_len, tag, ticks, exp_len);
    chk(int'(result_o) == vin, "R7 code", result_o, vin);
    chk(!start_o && !busy_o, "R8 single stop", start_o, 0);
    clr_flag();
    #2;
    chk(!flag_o, "R10 cleared", flag_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int seen, drops, held;
    repeat (3) @(negedge clk);
    #2;
    chk(!adc_tick_o && !busy_o && !start_o && !sample_o && !flag_o &&
        dac_o == 0 && result_o == 0, "R12 reset", flag_o, 0);
    @(negedge clk); rst_n = 1'b1; model_on = 1;
    // start while disabled is ignored
    pulse_start();
    repeat (20) @(negedge clk);
    #2;
    chk(!start_o && !busy_o && !adc_tick_o, "R2,R3 disabled", start_o, 0);
    // first conversion, /2
    en_i = 1'b1; psel_i = 3'd0; vin = 677;
    run_one(25, "R5 first length");
    vin = 346; psel_i = 3'd2;
    run_one(13, "R4 normal length");
    vin = 0; psel_i = 3'd5;
    run_one(13, "R4 zero code");
    vin = 1023; psel_i = 3'd1;
    run_one(13, "R4 full code");
    // free running with clear held high (set wins on completion)
    psel_i = 3'd3; vin = 100; free_run_i = 1'b1; flag_clr_i = 1'b1;
    pulse_start();
    while (!busy_o) @(negedge clk);
    drops = 0; seen = 0; held = 0;
    while (seen < 3) begin
      @(negedge clk);
      if (!busy_o) drops++;
      if (flag_o) begin
        #2;
        seen++;
        chk(int'(result_o) == vin, "R7,R9 free code", result_o, vin);
        @(negedge clk); #2;
        chk(!flag_o, "R10 set wins then clear", flag_o, 0);
        if (busy_o && start_o) held++;
        vin = vin + 211;
      end
    end
    chk(drops == 0 && held == 3, "R9 back to back", drops, 0);
    flag_clr_i = 1'b0; free_run_i = 1'b0;
    while (!flag_o) @(negedge clk);
    #2;
    chk(!start_o && !busy_o, "R8 free off stops", start_o, 0);
    clr_flag();
    // abort in the middle of a /128 conversion
    psel_i = 3'd7; held = int'(result_o); vin = 55;
    pulse_start();
    repeat (900) @(negedge clk);
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy_o && !start_o && dac_o == 0, "R11 aborted", busy_o, 0);
    chk(int'(result_o) == held, "R11 result kept", result_o, held);
    chk(!flag_o, "R11 no flag", flag_o, 0);
    en_i = 1'b1; vin = 500;
    run_one(25, "R11 first re-armed");
    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule